// File: doc/BRIEF.md
# Selective Invalidation Engine for a Tagged Protection-Lookup Cache

This block holds a small cache of memory-protection-table lookup results. Each entry carries a valid bit, a domain tag, a page number and a result field. A single invalidate command carries five operands: a range-enable flag, a domain-enable flag, a range-size bit, a page number and a domain. The engine then walks the entries and clears every valid entry that lies in the selected range and belongs to the selected domain. When a flag is clear, its operand is ignored and that dimension covers everything. The two flags together choose among four scopes: everything, one domain, one range across all domains, or one range within one domain.

The range is either one 4 KiB page or a naturally aligned power-of-two block. The size of that block comes from the run of one bits at the bottom of the page number. The walk visits one entry per clock. While it runs, lookups are held off with a stall indication. When it finishes, a one-cycle done pulse is issued. The cache is loaded through a simple indexed write port, and lookups answer one cycle after they are requested. A parameter builds a reduced variant that ignores every operand and always clears the whole cache.

Top module: `mtt_inval_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and `inv_busy` and `inv_done` are 0.
- R2: While idle, `fill_en` writes domain, page number and result into entry `fill_idx` and marks it valid. A lookup accepted on one edge raises `lkp_ack` in the next cycle. In that cycle `lkp_hit` is 1 only if a valid entry matches both the domain and the page number exactly, and `lkp_res` then carries the result of the lowest-indexed such entry.
- R3: With range flag 0 and domain flag 0, every entry is invalidated.
- R4: With range flag 0 and domain flag 1, only entries whose domain equals `inv_dom` are invalidated.
- R5: With range flag 1 and domain flag 0, entries inside the range are invalidated whatever their domain.
- R6: With both flags 1, only entries that are inside the range and also carry domain `inv_dom` are invalidated.
- R7: With `inv_napot` = 0, the range is exactly the page `inv_ppn`.
- R8: With `inv_napot` = 1, let x be the lowest zero bit position of `inv_ppn`. The range covers 2^(x+1) pages, which is 1 << (12+x+1) bytes, aligned so that page number bits [x:0] are ignored. If `inv_ppn` has no zero bit, the range covers every page.
- R9: An operand whose flag is 0 has no effect: the page number and size bit when the range flag is 0, and the domain when the domain flag is 0.
- R10: An `inv_req` seen while idle is accepted on that edge, and `inv_busy` is 1 from the next cycle. `inv_done` is high for exactly one cycle, N edges after the accepting edge, where N is the entry count. It coincides with `inv_busy` returning to 0.
- R11: While `inv_busy` is 1, `lkp_stall` follows `lkp_req` and the lookup gets no ack. A fill or a further `inv_req` during this time is ignored.
- R12: With `GLOBAL_ONLY` = 1, every invalidate clears all entries regardless of its operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write one entry |
| fill_idx | input | IW | Entry index to write |
| fill_dom | input | DW | Domain tag to store |
| fill_ppn | input | PW | Page number to store |
| fill_res | input | RW | Lookup result to store |
| lkp_req | input | 1 | Lookup request |
| lkp_dom | input | DW | Lookup domain |
| lkp_ppn | input | PW | Lookup page number |
| lkp_stall | output | 1 | Lookup held off by a running walk |
| lkp_ack | output | 1 | Lookup answer valid |
| lkp_hit | output | 1 | Lookup hit |
| lkp_res | output | RW | Result of the hitting entry |
| inv_req | input | 1 | Start an invalidate |
| inv_ppn_vld | input | 1 | Range operand enable |
| inv_dom_vld | input | 1 | Domain operand enable |
| inv_napot | input | 1 | 0: single page, 1: power-of-two block |
| inv_ppn | input | PW | Range page number |
| inv_dom | input | DW | Domain operand |
| inv_busy | output | 1 | Walk in progress |
| inv_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is the interplay of a running walk with new traffic. That means a lookup, a fill and a second invalidate all arriving mid-walk. The stimulus injects all three two cycles after the accepting edge. It then shows, through later lookups, that the fill never landed. It also shows that the done pulse appears once, at the expected edge. The block-range decode is reached with page numbers that have one, three and all low bits set, and the cache holds entries that straddle each block boundary in several domains.

// File: rtl/mtt_inval_cache.sv
module mtt_inval_cache #(
  parameter int N           = 8,
  parameter int DW          = 8,
  parameter int PW          = 44,
  parameter int RW          = 4,
  parameter int GLOBAL_ONLY = 0,
  localparam int IW         = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  logic [DW-1:0] fill_dom,
  input  logic [PW-1:0] fill_ppn,
  input  logic [RW-1:0] fill_res,
  input  logic          lkp_req,
  input  logic [DW-1:0] lkp_dom,
  input  logic [PW-1:0] lkp_ppn,
  output logic          lkp_stall,
  output logic          lkp_ack,
  output logic          lkp_hit,
  output logic [RW-1:0] lkp_res,
  input  logic          inv_req,
  input  logic          inv_ppn_vld,
  input  logic          inv_dom_vld,
  input  logic          inv_napot,
  input  logic [PW-1:0] inv_ppn,
  input  logic [DW-1:0] inv_dom,
  output logic          inv_busy,
  output logic          inv_done
);

  logic [N-1:0]  e_vld;
  logic [DW-1:0] e_dom [N];
  logic [PW-1:0] e_ppn [N];
  logic [RW-1:0] e_res [N];

  logic          busy;
  logic [IW-1:0] idx;
  logic          q_ppnv, q_domv;
  logic [PW-1:0] q_ppn, q_mask;
  logic [DW-1:0] q_dom;
  logic          use_ppnv, use_domv;

  generate
    if (GLOBAL_ONLY != 0) begin : g_glob
      assign use_ppnv = 1'b0;
      assign use_domv = 1'b0;
    end else begin : g_sel
      assign use_ppnv = inv_ppn_vld;
      assign use_domv = inv_dom_vld;
    end
  endgenerate

  wire           accept   = inv_req && !busy;
  wire [PW-1:0]  new_mask = inv_napot ? (inv_ppn ^ (inv_ppn + PW'(1))) : '0;
  wire           rng_hit  = !q_ppnv || ((e_ppn[idx] & ~q_mask) == (q_ppn & ~q_mask));
  wire           dom_hit  = !q_domv || (e_dom[idx] == q_dom);
  wire           last     = (idx == IW'(N - 1));

  logic          hit_c;
  logic [RW-1:0] res_c;

  always_comb begin
    hit_c = 1'b0;
    res_c = '0;
    for (int i = N - 1; i >= 0; i--)
      if (e_vld[i] && e_dom[i] == lkp_dom && e_ppn[i] == lkp_ppn) begin
        hit_c = 1'b1;
        res_c = e_res[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld    <= '0;
      busy     <= 1'b0;
      idx      <= '0;
      inv_done <= 1'b0;
      lkp_ack  <= 1'b0;
      lkp_hit  <= 1'b0;
      lkp_res  <= '0;
      q_ppnv   <= 1'b0;
      q_domv   <= 1'b0;
      q_ppn    <= '0;
      q_mask   <= '0;
      q_dom    <= '0;
    end else begin
      inv_done <= 1'b0;
      lkp_ack  <= lkp_req && !busy;
      lkp_hit  <= lkp_req && !busy && hit_c;
      lkp_res  <= (lkp_req && !busy && hit_c) ? res_c : '0;
      if (fill_en && !busy)
        e_vld[fill_idx] <= 1'b1;
      if (accept) begin
        busy   <= 1'b1;
        idx    <= '0;
        q_ppnv <= use_ppnv;
        q_domv <= use_domv;
        q_ppn  <= inv_ppn;
        q_mask <= new_mask;
        q_dom  <= inv_dom;
      end else if (busy) begin
        if (rng_hit && dom_hit)
          e_vld[idx] <= 1'b0;
        if (last) begin
          busy     <= 1'b0;
          inv_done <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !busy) begin
      e_dom[fill_idx] <= fill_dom;
      e_ppn[fill_idx] <= fill_ppn;
      e_res[fill_idx] <= fill_res;
    end
  end

  assign inv_busy  = busy;
  assign lkp_stall = lkp_req && busy;

endmodule

// File: rtl/mtt_inval_cache_chk.sv
module mtt_inval_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic lkp_req,
  input logic lkp_ack,
  input logic lkp_hit,
  input logic inv_req,
  input logic inv_busy,
  input logic inv_done
);

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req && !inv_busy |=> inv_busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |=> !inv_done);

  assert_done_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inv_busy) |-> inv_done);

  assert_no_ack_in_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req && inv_busy |=> !lkp_ack);

  assert_ack_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req && !inv_busy |=> lkp_ack);

  assert_hit_needs_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |-> lkp_ack);

endmodule

bind mtt_inval_cache mtt_inval_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lkp_req(lkp_req), .lkp_ack(lkp_ack),
  .lkp_hit(lkp_hit), .inv_req(inv_req), .inv_busy(inv_busy), .inv_done(inv_done)
);

// File: tb/tb_mtt_inval_cache.sv
`timescale 1ns/1ps
module tb_mtt_inval_cache;
  localparam int N = 8, DW = 8, PW = 44, RW = 4, IW = 3;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic          fill_en = 0;
  logic [IW-1:0] fill_idx = 0;
  logic [DW-1:0] fill_dom = 0;
  logic [PW-1:0] fill_ppn = 0;
  logic [RW-1:0] fill_res = 0;
  logic          lkp_req = 0;
  logic [DW-1:0] lkp_dom = 0;
  logic [PW-1:0] lkp_ppn = 0;
  logic          inv_req = 0, inv_ppn_vld = 0, inv_dom_vld = 0, inv_napot = 0;
  logic [PW-1:0] inv_ppn = 0;
  logic [DW-1:0] inv_dom = 0;
  logic          lkp_stall, lkp_ack, lkp_hit, inv_busy, inv_done;
  logic [RW-1:0] lkp_res;
  logic          g_stall, g_ack, g_hit, g_busy, g_done;
  logic [RW-1:0] g_res;

  mtt_inval_cache #(.N(N), .DW(DW), .PW(PW), .RW(RW)) dut (
    .clk, .rst_n, .fill_en, .fill_idx, .fill_dom, .fill_ppn, .fill_res,
    .lkp_req, .lkp_dom, .lkp_ppn, .lkp_stall, .lkp_ack, .lkp_hit, .lkp_res,
    .inv_req, .inv_ppn_vld, .inv_dom_vld, .inv_napot, .inv_ppn, .inv_dom,
    .inv_busy, .inv_done);

  mtt_inval_cache #(.N(N), .DW(DW), .PW(PW), .RW(RW), .GLOBAL_ONLY(1)) dut_g (
    .clk, .rst_n, .fill_en, .fill_idx, .fill_dom, .fill_ppn, .fill_res,
    .lkp_req, .lkp_dom, .lkp_ppn, .lkp_stall(g_stall), .lkp_ack(g_ack),
    .lkp_hit(g_hit), .lkp_res(g_res),
    .inv_req, .inv_ppn_vld, .inv_dom_vld, .inv_napot, .inv_ppn, .inv_dom,
    .inv_busy(g_busy), .inv_done(g_done));

  int total = 0, bad = 0;
  bit finished = 0;

  bit            m_vld [N];
  bit            g_vld [N];
  logic [DW-1:0] m_dom [N];
  logic [PW-1:0] m_ppn [N];
  logic [RW-1:0] m_res [N];

  logic [RW+1:0] exp_q [$];
  string         tag_q [$];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit in_range(logic [PW-1:0] e, logic [PW-1:0] q, bit napot);
    int x;
    if (!napot) return e == q;
    x = -1;
    for (int b = 0; b < PW; b++) if (x < 0 && !q[b]) x = b;
    if (x < 0) return 1;
    return (e >> (x + 1)) == (q >> (x + 1));
  endfunction

  task automatic fill(int i, logic [DW-1:0] d, logic [PW-1:0] p, logic [RW-1:0] r);
    @(negedge clk);
    fill_en = 1; fill_idx = IW'(i); fill_dom = d; fill_ppn = p; fill_res = r;
    @(negedge clk);
    fill_en = 0;
    m_vld[i] = 1; g_vld[i] = 1; m_dom[i] = d; m_ppn[i] = p; m_res[i] = r;
  endtask

  task automatic look(logic [DW-1:0] d, logic [PW-1:0] p, string tag);
    bit h = 0, gh = 0;
    logic [RW-1:0] r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_vld[i] && m_dom[i] == d && m_ppn[i] == p) begin h = 1; r = m_res[i]; end
      if (g_vld[i] && m_dom[i] == d && m_ppn[i] == p) gh = 1;
    end
    @(negedge clk);
    lkp_req = 1; lkp_dom = d; lkp_ppn = p;
    exp_q.push_back({gh, h, r});
    tag_q.push_back(tag);
    @(negedge clk);
    lkp_req = 0;
  endtask

  always @(negedge clk) begin
    if (lkp_ack) begin
      if (exp_q.size() == 0) begin
        chk(0, "R11", "unexpected lookup ack", 1, 0);
      end else begin
        logic [RW+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(lkp_hit == e[RW], t, "hit", lkp_hit, e[RW]);
        if (e[RW]) chk(lkp_res == e[RW-1:0], t, "result", lkp_res, e[RW-1:0]);
        chk(g_hit == e[RW+1], "R12", "global variant hit", g_hit, e[RW+1]);
      end
    end
  end

  task automatic inval(bit pv, bit dv, bit nap, logic [PW-1:0] p, logic [DW-1:0] d, bit probe);
    @(negedge clk);
    inv_req = 1; inv_ppn_vld = pv; inv_dom_vld = dv; inv_napot = nap; inv_ppn = p; inv_dom = d;
    for (int k = 1; k <= N + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        inv_req = 0;
        chk(inv_busy == 1, "R10", "busy after accept", inv_busy, 1);
      end
      if (probe && k == 2) begin
        lkp_req = 1; lkp_dom = 8'h77; lkp_ppn = 44'h3333;
        fill_en = 1; fill_idx = 0; fill_dom = 8'h77; fill_ppn = 44'h3333; fill_res = 4'h9;
        inv_req = 1; inv_ppn_vld = 0; inv_dom_vld = 0;
        #1;
        chk(lkp_stall == 1, "R11", "stall during walk", lkp_stall, 1);
      end
      if (probe && k == 3) begin
        lkp_req = 0; fill_en = 0; inv_req = 0;
      end
      chk(inv_done == (k == N + 1), "R10", $sformatf("done at step %0d", k), inv_done, k == N + 1);
    end
    for (int i = 0; i < N; i++) begin
      if ((!pv || in_range(m_ppn[i], p, nap)) && (!dv || m_dom[i] == d)) m_vld[i] = 0;
      g_vld[i] = 0;
    end
    @(negedge clk);
    chk(inv_done == 0 && inv_busy == 0, "R10", "idle after done", {inv_busy, inv_done}, 0);
  endtask

  task automatic load_all();
    fill(0, 8'd1, 44'h1000, 4'h1);
    fill(1, 8'd1, 44'h1001, 4'h2);
    fill(2, 8'd2, 44'h1003, 4'h3);
    fill(3, 8'd2, 44'h1004, 4'h4);
    fill(4, 8'd3, 44'h1008, 4'h5);
    fill(5, 8'd1, 44'h2000, 4'h6);
    fill(6, 8'd2, 44'h1000, 4'h7);
    fill(7, 8'd3, 44'hFFF_FFFF_FFFF, 4'h8);
  endtask

  task automatic look_all(string tag);
    look(8'd1, 44'h1000, tag); look(8'd1, 44'h1001, tag);
    look(8'd2, 44'h1003, tag); look(8'd2, 44'h1004, tag);
    look(8'd3, 44'h1008, tag); look(8'd1, 44'h2000, tag);
    look(8'd2, 44'h1000, tag); look(8'd3, 44'hFFF_FFFF_FFFF, tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; g_vld[i] = 0; m_dom[i] = 0; m_ppn[i] = 0; m_res[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(inv_busy == 0, "R1", "busy after reset", inv_busy, 0);
    chk(inv_done == 0, "R1", "done after reset", inv_done, 0);
    look(8'd1, 44'h1000, "R1");
    look(8'd0, 44'h0, "R1");

    load_all();
    look_all("R2");
    look(8'd9, 44'h1000, "R2");
    look(8'd1, 44'h1002, "R2");

    inval(1, 0, 0, 44'h1000, 8'd5, 0);
    look_all("R7 R5");

    load_all();
    inval(1, 1, 1, 44'h1001, 8'd2, 1);
    look_all("R6 R8");
    look(8'h77, 44'h3333, "R11");

    load_all();
    inval(0, 1, 1, 44'h1000, 8'd1, 0);
    look_all("R4 R9");

    load_all();
    inval(1, 0, 1, 44'hFFF_FFFF_FFFF, 8'd0, 0);
    look_all("R8");

    load_all();
    inval(1, 0, 1, 44'h1007, 8'd3, 0);
    look_all("R8 R5");

    load_all();
    inval(0, 0, 0, 44'h1000, 8'd3, 0);
    look_all("R3 R9");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "pending lookups", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule